// File: doc/BRIEF.md
# PLL Frequency Calculator

This block works out, in hertz, the frequencies of three clocks: the processor clock, the high-speed clock derived from it, and the peripheral bus clock derived from that. It takes its inputs from three 32-bit configuration words: a mode word, a post-divider word and a main PLL control word. It does not make any clock. Its results are numbers for software models, timer set-up logic, or any consumer that has to know the current rates.

A one-cycle `start` pulse captures the three words and the block raises `busy`. The block first picks the reference frequency. It then checks the bypass conditions. When the PLL is in use, it evaluates the fractional-N formula, in which the numerator is signed and the integer field is clamped. It then divides the processor clock by the two post-dividers in turn. All three divisions run on one shared restoring divider, which produces one quotient bit per cycle. When the last division ends, the three outputs update together and `done` pulses for one cycle.

Top module: `pll_freq_calc`

## Requirements
- R1: The reference is 33,554,432 Hz when mode bits 2:1 equal 2'b01. For any other value of those bits it is 26,000,000 Hz.
- R2: The processor clock equals the reference when mode bit 7 is 1 or mode bit 3 is 0.
- R3: With the PLL in use, the PLL word fields are: pre-divider P at bits 29:26, denominator D at 25:16, integer I at 13:10 and numerator N at 9:0. Let i = max(I,5), d = D+1 and p = P+1. Then q = (2·(ref>>10)·(i·d+N)) / (d·p), using unsigned integer division.
- R4: N is a 10-bit two's-complement value. When i·d+N is zero or negative, the processor clock is 0.
- R5: The processor clock is q shifted left by 10. Only the low 32 bits are kept.
- R6: The high-speed clock is the processor clock divided by (1 + post word bits 13:11), rounded down.
- R7: The peripheral bus clock is the high-speed clock divided by (1 + post word bits 7:6), rounded down.
- R8: Every division gives the exact unsigned quotient: quotient·divisor + remainder equals the dividend, and the remainder is less than the divisor.
- R9: In the cycle after an accepted `start`, `busy` is 1. `done` is a single-cycle pulse and is never high while `busy` is high.
- R10: The three frequency outputs change only in the cycle in which `done` is high.
- R11: A `start` that arrives while `busy` is high is ignored. The configuration words are sampled only when `start` is accepted.
- R12: After reset, all three outputs are 0 and both `busy` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a computation (accepted only when idle) |
| mode_word | input | 32 | Mode word: reference select and bypass bits |
| post_word | input | 32 | Post-divider word |
| pll_word | input | 32 | Main PLL control word |
| busy | output | 1 | A computation is in progress |
| done | output | 1 | One-cycle pulse when new results are available |
| cpu_hz | output | 32 | Processor clock frequency in Hz |
| hsp_hz | output | 32 | High-speed clock frequency in Hz |
| ipg_hz | output | 32 | Peripheral bus clock frequency in Hz |

## Verification
The divider assertions take for granted that the divisor is never zero when a division starts. The +1 offsets on every field that feeds a divisor keep this true for any input word. Because of that, the stimulus draws all three words over their full random range instead of filtering them. The random draws and the directed cases also reach the region where i·d+N is zero or negative, and the region where q<<10 overflows 32 bits. Some starts are issued while busy, and the configuration inputs are scrambled after capture, so the hold and ignore properties are exercised in the same runs that check the arithmetic.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam int unsigned PFC_WORD_W    = 32;
  localparam int unsigned PFC_PROD_W    = 48;
  localparam int unsigned PFC_DVSR_W    = 16;
  localparam int unsigned PFC_FRAC_SH   = 10;
  localparam int unsigned PFC_REF_HI_HZ = 26000000;
  localparam int unsigned PFC_REF_LO_HZ = 33554432;
  localparam int unsigned PFC_MFI_FLOOR = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PLL_GO,
    ST_PLL_WAIT,
    ST_HSP_GO,
    ST_HSP_WAIT,
    ST_IPG_GO,
    ST_IPG_WAIT
  } calc_st_e;
endpackage

// File: rtl/pfc_pll_decode.sv
module pfc_pll_decode #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned PROD_W    = 48,
  parameter int unsigned DVSR_W    = 16,
  parameter int unsigned FRAC_SH   = 10,
  parameter int unsigned REF_HI_HZ = 26000000,
  parameter int unsigned REF_LO_HZ = 33554432,
  parameter int unsigned MFI_FLOOR = 5
) (
  input  logic [1:0]        ref_sel,
  input  logic              force_bypass,
  input  logic              pll_enable,
  input  logic [3:0]        pre_fld,
  input  logic [9:0]        den_fld,
  input  logic [3:0]        int_fld,
  input  logic [9:0]        num_fld,
  output logic [WORD_W-1:0] ref_hz,
  output logic              bypass,
  output logic              term_pos,
  output logic [PROD_W-1:0] dividend,
  output logic [DVSR_W-1:0] divisor
);
  logic [4:0]         int_eff;
  logic [10:0]        den_eff;
  logic [4:0]         pre_eff;
  logic [15:0]        int_den;
  logic signed [17:0] num_ext;
  logic signed [17:0] term;
  logic [WORD_W-1:0]  ref_scaled;

  always_comb begin
    ref_hz     = (ref_sel == 2'b01) ? WORD_W'(REF_LO_HZ) : WORD_W'(REF_HI_HZ);
    bypass     = force_bypass | ~pll_enable;
    int_eff    = (int_fld < 4'(MFI_FLOOR)) ? 5'(MFI_FLOOR) : {1'b0, int_fld};
    den_eff    = {1'b0, den_fld} + 11'd1;
    pre_eff    = {1'b0, pre_fld} + 5'd1;
    int_den    = 16'(int_eff) * 16'(den_eff);
    num_ext    = {{8{num_fld[9]}}, num_fld};
    term       = $signed({2'b00, int_den}) + num_ext;
    term_pos   = !term[17] && (term != 18'sd0);
    ref_scaled = ref_hz >> FRAC_SH;
    dividend   = (PROD_W'(ref_scaled) * PROD_W'(term[16:0])) << 1;
    divisor    = DVSR_W'(den_eff) * DVSR_W'(pre_eff);
  end
endmodule

// File: rtl/pfc_divider.sv
module pfc_divider #(
  parameter int unsigned NUM_W = 48,
  parameter int unsigned DEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] numer,
  input  logic [DEN_W-1:0] denom,
  output logic             busy,
  output logic             done,
  output logic [NUM_W-1:0] quot
);
  localparam int unsigned CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] q_r, q_n, num_r, num_n;
  logic [DEN_W:0]   rem_r, rem_n, shifted;
  logic [DEN_W+1:0] diff;
  logic [DEN_W-1:0] den_r, den_n;
  logic [CNT_W-1:0] cnt_r, cnt_n;
  logic             run_r, run_n, done_r, done_n;

  always_comb begin
    q_n     = q_r;
    num_n   = num_r;
    rem_n   = rem_r;
    den_n   = den_r;
    cnt_n   = cnt_r;
    run_n   = run_r;
    done_n  = 1'b0;
    shifted = {rem_r[DEN_W-1:0], q_r[NUM_W-1]};
    diff    = {1'b0, shifted} - {2'b00, den_r};
    if (start && !run_r) begin
      q_n   = numer;
      num_n = numer;
      rem_n = '0;
      den_n = denom;
      cnt_n = CNT_W'(NUM_W);
      run_n = 1'b1;
    end else if (run_r) begin
      q_n   = {q_r[NUM_W-2:0], ~diff[DEN_W+1]};
      rem_n = diff[DEN_W+1] ? shifted : diff[DEN_W:0];
      cnt_n = cnt_r - 1'b1;
      if (cnt_r == CNT_W'(1)) begin
        run_n  = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r    <= '0;
      num_r  <= '0;
      rem_r  <= '0;
      den_r  <= '0;
      cnt_r  <= '0;
      run_r  <= 1'b0;
      done_r <= 1'b0;
    end else begin
      q_r    <= q_n;
      num_r  <= num_n;
      rem_r  <= rem_n;
      den_r  <= den_n;
      cnt_r  <= cnt_n;
      run_r  <= run_n;
      done_r <= done_n;
    end
  end

  assign busy = run_r;
  assign done = done_r;
  assign quot = q_r;

  // R8: a division is never launched with a zero divisor
  a_r8_divisor_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !run_r) |-> (denom != '0));

  // R8: the result is exact when it is presented
  a_r8_div_exact: assert property (@(posedge clk) disable iff (!rst_n)
    done_r |-> (((NUM_W+DEN_W)'(q_r) * (NUM_W+DEN_W)'(den_r) + (NUM_W+DEN_W)'(rem_r))
                 == (NUM_W+DEN_W)'(num_r)) && (rem_r < {1'b0, den_r}));
endmodule

// File: rtl/pll_freq_calc.sv
module pll_freq_calc
  import pfc_pkg::*;
#(
  parameter int unsigned WORD_W    = PFC_WORD_W,
  parameter int unsigned PROD_W    = PFC_PROD_W,
  parameter int unsigned DVSR_W    = PFC_DVSR_W,
  parameter int unsigned FRAC_SH   = PFC_FRAC_SH,
  parameter int unsigned REF_HI_HZ = PFC_REF_HI_HZ,
  parameter int unsigned REF_LO_HZ = PFC_REF_LO_HZ,
  parameter int unsigned MFI_FLOOR = PFC_MFI_FLOOR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       mode_word,
  input  logic [31:0]       post_word,
  input  logic [31:0]       pll_word,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] cpu_hz,
  output logic [WORD_W-1:0] hsp_hz,
  output logic [WORD_W-1:0] ipg_hz
);
  calc_st_e          st_r, st_n;
  logic [31:0]       mode_r, post_r, pll_r;
  logic [WORD_W-1:0] cpu_r, cpu_n, hsp_r, hsp_n;
  logic [WORD_W-1:0] cpu_o, hsp_o, ipg_o;
  logic              done_r, done_n, cap_en, out_en;
  logic              div_go, div_busy, div_done;
  logic [PROD_W-1:0] div_num, div_quot, pll_dividend;
  logic [DVSR_W-1:0] div_den, pll_divisor;
  logic [WORD_W-1:0] ref_hz;
  logic              bypass, term_pos;
  logic              unused_bits;

  pfc_pll_decode #(
    .WORD_W(WORD_W), .PROD_W(PROD_W), .DVSR_W(DVSR_W), .FRAC_SH(FRAC_SH),
    .REF_HI_HZ(REF_HI_HZ), .REF_LO_HZ(REF_LO_HZ), .MFI_FLOOR(MFI_FLOOR)
  ) u_decode (
    .ref_sel      (mode_r[2:1]),
    .force_bypass (mode_r[7]),
    .pll_enable   (mode_r[3]),
    .pre_fld      (pll_r[29:26]),
    .den_fld      (pll_r[25:16]),
    .int_fld      (pll_r[13:10]),
    .num_fld      (pll_r[9:0]),
    .ref_hz       (ref_hz),
    .bypass       (bypass),
    .term_pos     (term_pos),
    .dividend     (pll_dividend),
    .divisor      (pll_divisor)
  );

  pfc_divider #(.NUM_W(PROD_W), .DEN_W(DVSR_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_go),
    .numer (div_num),
    .denom (div_den),
    .busy  (div_busy),
    .done  (div_done),
    .quot  (div_quot)
  );

  assign unused_bits = ^{mode_r[31:8], mode_r[6:4], mode_r[0], post_r[31:14],
                         post_r[10:8], post_r[5:0], pll_r[31:30], pll_r[15:14],
                         div_quot[PROD_W-1:WORD_W], div_busy};

  assign cap_en = start && (st_r == ST_IDLE);

  always_comb begin
    st_n    = st_r;
    cpu_n   = cpu_r;
    hsp_n   = hsp_r;
    div_go  = 1'b0;
    div_num = '0;
    div_den = DVSR_W'(1);
    out_en  = 1'b0;
    done_n  = 1'b0;
    case (st_r)
      ST_IDLE: if (start) st_n = ST_PLL_GO;
      ST_PLL_GO: begin
        if (bypass) begin
          cpu_n = ref_hz;
          st_n  = ST_HSP_GO;
        end else if (!term_pos) begin
          cpu_n = '0;
          st_n  = ST_HSP_GO;
        end else begin
          div_go  = 1'b1;
          div_num = pll_dividend;
          div_den = pll_divisor;
          st_n    = ST_PLL_WAIT;
        end
      end
      ST_PLL_WAIT: if (div_done) begin
        cpu_n = WORD_W'(div_quot << FRAC_SH);
        st_n  = ST_HSP_GO;
      end
      ST_HSP_GO: begin
        div_go  = 1'b1;
        div_num = PROD_W'(cpu_r);
        div_den = DVSR_W'(post_r[13:11]) + DVSR_W'(1);
        st_n    = ST_HSP_WAIT;
      end
      ST_HSP_WAIT: if (div_done) begin
        hsp_n = WORD_W'(div_quot);
        st_n  = ST_IPG_GO;
      end
      ST_IPG_GO: begin
        div_go  = 1'b1;
        div_num = PROD_W'(hsp_r);
        div_den = DVSR_W'(post_r[7:6]) + DVSR_W'(1);
        st_n    = ST_IPG_WAIT;
      end
      ST_IPG_WAIT: if (div_done) begin
        out_en = 1'b1;
        done_n = 1'b1;
        st_n   = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_r   <= ST_IDLE;
      mode_r <= '0;
      post_r <= '0;
      pll_r  <= '0;
      cpu_r  <= '0;
      hsp_r  <= '0;
      cpu_o  <= '0;
      hsp_o  <= '0;
      ipg_o  <= '0;
      done_r <= 1'b0;
    end else begin
      st_r   <= st_n;
      cpu_r  <= cpu_n;
      hsp_r  <= hsp_n;
      done_r <= done_n;
      if (cap_en) begin
        mode_r <= mode_word;
        post_r <= post_word;
        pll_r  <= pll_word;
      end
      if (out_en) begin
        cpu_o <= cpu_r;
        hsp_o <= hsp_r;
        ipg_o <= WORD_W'(div_quot);
      end
    end
  end

  assign busy   = (st_r != ST_IDLE);
  assign done   = done_r;
  assign cpu_hz = cpu_o;
  assign hsp_hz = hsp_o;
  assign ipg_hz = ipg_o;

  // R9: done never overlaps busy, and it lasts one cycle
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_r |-> !busy);
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_r |=> !done_r);

  // R10: the outputs hold between done pulses
  a_r10_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !done_r |-> ($stable(cpu_o) && $stable(hsp_o) && $stable(ipg_o)));

  // R11: a start while busy leaves the captured words untouched
  a_r11_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> ($stable(mode_r) && $stable(post_r) && $stable(pll_r)));

  // R2: in bypass the processor result is the selected reference
  a_r2_bypass_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (st_r == ST_PLL_GO && bypass) |=> (cpu_r == $past(ref_hz)));

  // R6, R7: post-divided clocks never exceed their source
  a_r6_r7_not_larger: assert property (@(posedge clk) disable iff (!rst_n)
    done_r |-> ((hsp_o <= cpu_o) && (ipg_o <= hsp_o)));
endmodule

// File: tb/pll_freq_calc_tb.sv
module pll_freq_calc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_LIMIT  = 1000;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [31:0] mode_word, post_word, pll_word;
  logic        busy, done;
  logic [31:0] cpu_hz, hsp_hz, ipg_hz;

  int n_chk;
  int n_bad;

  pll_freq_calc dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mode_word(mode_word), .post_word(post_word), .pll_word(pll_word),
    .busy(busy), .done(done),
    .cpu_hz(cpu_hz), .hsp_hz(hsp_hz), .ipg_hz(ipg_hz)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d (0x%08h) expected %0d (0x%08h)",
               req, what, act, act, exp, exp);
    end
  endtask

  function automatic void model(input logic [31:0] m, input logic [31:0] p,
                                input logic [31:0] w, output logic [31:0] c,
                                output logic [31:0] h, output logic [31:0] i);
    longint r, mi, md, mp, mn, term, q;
    r  = (m[2:1] == 2'b01) ? 64'd33554432 : 64'd26000000;
    mi = longint'(w[13:10]);
    if (mi < 5) mi = 5;
    md = longint'(w[25:16]) + 1;
    mp = longint'(w[29:26]) + 1;
    mn = longint'($signed(w[9:0]));
    term = mi * md + mn;
    if (m[7] || !m[3]) c = 32'(r);
    else if (term <= 0) c = 32'd0;
    else begin
      q = (2 * (r >>> 10) * term) / (md * mp);
      c = 32'(q << 10);
    end
    h = c / (32'd1 + 32'(p[13:11]));
    i = h / (32'd1 + 32'(p[7:6]));
  endfunction

  // Runs one computation; inject=1 issues a second start while busy (R11)
  task automatic run_case(input string req, input logic [31:0] m,
                          input logic [31:0] p, input logic [31:0] w,
                          input bit inject);
    logic [31:0] ec, eh, ei, pc, ph, pi;
    bit held;
    int waited;
    model(m, p, w, ec, eh, ei);
    pc = cpu_hz; ph = hsp_hz; pi = ipg_hz;
    held = 1'b1;
    @(negedge clk);
    mode_word = m; post_word = p; pll_word = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    mode_word = $urandom; post_word = $urandom; pll_word = $urandom;
    check("R9", "busy after start", {31'd0, busy}, 32'd1);
    waited = 0;
    while (!done && waited < RUN_LIMIT) begin
      if (cpu_hz !== pc || hsp_hz !== ph || ipg_hz !== pi) held = 1'b0;
      if (done !== 1'b0 || busy !== 1'b1) held = 1'b0;
      if (inject && waited == 3) start = 1'b1;
      if (inject && waited == 4) start = 1'b0;
      @(negedge clk);
      waited++;
    end
    start = 1'b0;
    if (waited >= RUN_LIMIT) begin
      n_chk++; n_bad++;
      $display("FAIL R9 done timeout: actual waited %0d expected < %0d", waited, RUN_LIMIT);
      return;
    end
    check("R10", "outputs held while busy", {31'd0, held}, 32'd1);
    check(req, "cpu_hz", cpu_hz, ec);
    check("R6", "hsp_hz", hsp_hz, eh);
    check("R7", "ipg_hz", ipg_hz, ei);
    check("R9", "busy low with done", {31'd0, busy}, 32'd0);
    @(negedge clk);
    check("R9", "done single cycle", {31'd0, done}, 32'd0);
  endtask

  localparam logic [31:0] M_HI   = 32'h0000_0008;
  localparam logic [31:0] M_LO   = 32'h0000_000A;
  localparam logic [31:0] M_S11  = 32'h0000_000E;
  localparam logic [31:0] W_BASE = (32'd1 << 26) | (32'd6 << 10);

  initial begin : main
    void'($urandom(32'd20240611));
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; start = 1'b0;
    mode_word = '0; post_word = '0; pll_word = '0;
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12", "cpu_hz reset", cpu_hz, 32'd0);
    check("R12", "hsp_hz reset", hsp_hz, 32'd0);
    check("R12", "ipg_hz reset", ipg_hz, 32'd0);
    check("R12", "busy reset", {31'd0, busy}, 32'd0);
    check("R12", "done reset", {31'd0, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run_case("R3", M_HI, 32'h0000_0B48, W_BASE, 1'b0);
    run_case("R1", M_LO, 32'h0000_0000,
             (32'd1 << 26) | (32'd4 << 16) | (32'd12 << 10) | 32'd1, 1'b0);
    run_case("R1", M_S11, 32'h0000_0040, W_BASE, 1'b0);
    run_case("R2", 32'h0000_0088, 32'h0000_0800, W_BASE, 1'b0);
    run_case("R2", 32'h0000_0002, 32'h0000_0000, W_BASE, 1'b0);
    run_case("R3", M_HI, 32'h0000_0000, (32'd2 << 16) | 32'd3, 1'b0);
    run_case("R4", M_LO, 32'h0000_0000,
             (32'd3 << 26) | (32'd9 << 16) | (32'd7 << 10) | 32'h3F0, 1'b0);
    run_case("R4", M_HI, 32'h0000_0000, (32'd5 << 10) | 32'h200, 1'b0);
    run_case("R4", M_HI, 32'h0000_0000, (32'd5 << 10) | 32'h3FB, 1'b0);
    run_case("R5", M_HI, 32'h0000_0000, (32'd15 << 10) | 32'h1FF, 1'b0);
    run_case("R6", M_HI, (32'd7 << 11) | (32'd3 << 6), W_BASE, 1'b0);
    run_case("R11", M_HI, (32'd2 << 11) | (32'd1 << 6),
             (32'd2 << 26) | (32'd7 << 16) | (32'd9 << 10) | 32'd33, 1'b1);

    for (int k = 0; k < 40; k++) begin
      logic [31:0] rm, rp, rw;
      rm = $urandom;
      rp = $urandom;
      rw = $urandom;
      if (k % 2 == 0) rm = (rm & ~32'h0000_0088) | 32'h0000_0008;
      run_case("R3", rm, rp, rw, (k % 7 == 0));
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R9 watchdog: actual hung expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule